// File: doc/BRIEF.md
# Manchester II Receiver with Sync Classification

This block turns a Manchester II encoded serial line into NRZ data with a recovered bit clock. The line arrives either as a complementary pair, one wire per polarity, or as a single-ended line. The block samples it with the system clock, which runs at 16 or 32 times the bit rate. It measures the time between transitions and from those times recovers bit timing, decodes bits, tells a command sync from a data sync, and catches cells that break the code.

Decoding only starts after a sync pattern. A sync holds one level for one and a half bit times and the opposite level for another one and a half. A command sync starts high and a data sync starts low. After a sync, every cell must change level at its midpoint. The direction of that change gives the bit. A receiver downstream samples `nrz_out` on each rising edge of `bit_clk` and uses `valid` to decide whether to trust the bit. A sync may follow the last bit of a word with no gap.

Top module: `manch_sync_decoder`

## Requirements
- R1: The decoded line level is `uni_in | (bip_one & ~bip_zero)`. For single-ended use, `bip_zero` is held at 1 and `bip_one` at 0. For pair use, `uni_in` is held at 0 and the pair carries complementary levels.
- R2: With `rate_sel`=1 one bit spans 32 clock cycles. With `rate_sel`=0 it spans 16. On an exact-rate stream, successive rising edges of `bit_clk` are one bit period apart.
- R3: A cell whose first half is high and second half is low decodes to 1. A cell whose first half is low and second half is high decodes to 0. Bits appear on `nrz_out` in the order they arrive.
- R4: `nrz_out` changes only in a cycle where `bit_clk` is low. `bit_clk` falls when a bit is decoded and rises half a bit period later, so each rising edge presents one decoded bit.
- R5: While `rst_n` is low at a clock edge, `nrz_out`, `bit_clk`, `valid` and `cmd_sync` are driven low.
- R6: After reset or a code violation, `valid` stays low until a sync has been recognised and two bits have been decoded after it. It rises together with the second bit. Transitions that arrive without a preceding sync decode nothing.
- R7: `cmd_sync` shows the type of the last recognised sync: 1 for command (high 1.5 bits, then low 1.5 bits) and 0 for data (low, then high).
- R8: A code violation drops `valid` and stops decoding until the next sync. A violation is either a full-bit run that starts at a cell boundary, which means the cell has no mid-cell transition, or a missing transition. A transition is missing if none arrives within 1.75 bit times of a boundary edge, or within 2.25 bit times of a mid-cell edge or a sync midpoint.
- R9: Each run between transitions is classed with a tolerance of plus or minus a quarter bit. With Q equal to a quarter bit in clocks, the classes are: half bit [Q,3Q), full bit [3Q,5Q), sync half [5Q,7Q) and double [7Q,9Q). A double run right after a sync midpoint closes the sync and decodes the first bit on the same edge.
- R10: A sync may directly follow the last bit of a word. This includes the case where the last half-bit and the first sync half have the same level and merge into a double run. `valid` stays high across the boundary and `cmd_sync` takes the new type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16x or 32x the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 1 | 1: 32 clocks per bit, 0: 16 clocks per bit |
| bip_zero | input | 1 | Pair input, low-polarity wire; held high in single-ended use |
| bip_one | input | 1 | Pair input, high-polarity wire; held low in single-ended use |
| uni_in | input | 1 | Single-ended line; held low in pair use |
| nrz_out | output | 1 | Decoded data, valid on the rising edge of bit_clk |
| bit_clk | output | 1 | Recovered 1X bit clock |
| valid | output | 1 | High when sync and the decoded bits so far are free of violations |
| cmd_sync | output | 1 | Type of the last sync: 1 command, 0 data |

## Verification
Two functions can fall on a single transition: closing a sync and decoding a bit. This happens when the first data bit starts at the level of the sync's second half, so one double run ends both the sync and the first cell. The mirror case also occurs when the last half-bit of a word merges with the first half of a following sync. The bench provokes both by choosing the first and last bit values of each frame. In the first case, the first recorded bit must be correct. In the second, the second word's bits must follow with `valid` held high and `cmd_sync` changed. Both cases are also run with stretched and shrunk half-bits, so the double-run window is hit near its edges.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SYNC = 2'd1,
    ST_BND  = 2'd2,
    ST_MID  = 2'd3
  } mdec_state_e;

  typedef enum logic [2:0] {
    RUN_BAD  = 3'd0,
    RUN_HALF = 3'd1,
    RUN_FULL = 3'd2,
    RUN_SYNC = 3'd3,
    RUN_DBL  = 3'd4
  } mdec_run_e;

  // Classify a run of len ticks; q is a quarter bit in ticks.
  function automatic mdec_run_e run_class(input int len, input int q);
    if (len < q)         return RUN_BAD;
    else if (len < 3*q)  return RUN_HALF;
    else if (len < 5*q)  return RUN_FULL;
    else if (len < 7*q)  return RUN_SYNC;
    else if (len < 9*q)  return RUN_DBL;
    else                 return RUN_BAD;
  endfunction

endpackage

// File: rtl/mdec_line_in.sv
module mdec_line_in #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bip_zero,
  input  logic bip_one,
  input  logic uni_in,
  output logic trans,
  output logic lvl
);
  logic line_raw;
  logic [SYNC_STAGES:0] sh;

  assign line_raw = uni_in | (bip_one & ~bip_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], line_raw};
  end

  assign lvl   = sh[SYNC_STAGES-1];
  assign trans = sh[SYNC_STAGES] ^ sh[SYNC_STAGES-1];
endmodule

// File: rtl/mdec_run_timer.sv
module mdec_run_timer
  import mdec_pkg::*;
#(
  parameter int OSR_LO = 16,
  parameter int OSR_HI = 32,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_sel,
  input  logic             trans,
  output logic [CNT_W-1:0] run_len,
  output mdec_run_e        run_cls,
  output logic [CNT_W-1:0] q_ticks,
  output logic [CNT_W-1:0] half_ticks
);
  localparam logic [CNT_W-1:0] Q_LO  = CNT_W'(OSR_LO / 4);
  localparam logic [CNT_W-1:0] Q_HI  = CNT_W'(OSR_HI / 4);
  localparam logic [CNT_W-1:0] H_LO  = CNT_W'(OSR_LO / 2);
  localparam logic [CNT_W-1:0] H_HI  = CNT_W'(OSR_HI / 2);
  localparam logic [CNT_W-1:0] SAT   = '1;

  assign q_ticks    = rate_sel ? Q_HI : Q_LO;
  assign half_ticks = rate_sel ? H_HI : H_LO;

  always_ff @(posedge clk) begin
    if (!rst_n)              run_len <= '0;
    else if (trans)          run_len <= CNT_W'(1);
    else if (run_len != SAT) run_len <= run_len + 1'b1;
  end

  assign run_cls = run_class(int'(run_len), int'(q_ticks));
endmodule

// File: rtl/mdec_frame_fsm.sv
module mdec_frame_fsm
  import mdec_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trans,
  input  logic             lvl,
  input  logic [CNT_W-1:0] run_len,
  input  mdec_run_e        run_cls,
  input  logic [CNT_W-1:0] q_ticks,
  output logic             dec_stb,
  output logic             dec_bit,
  output logic             sync_stb,
  output logic             sync_cmd,
  output logic             viol
);
  mdec_state_e st, nxt;
  logic [CNT_W-1:0] lim_bnd, lim_mid;

  assign lim_bnd = (q_ticks << 3) - q_ticks;
  assign lim_mid = (q_ticks << 3) + q_ticks;

  // Post-transition level low means a falling edge.
  assign dec_bit  = ~lvl;
  assign sync_cmd = ~lvl;

  always_comb begin
    nxt      = st;
    dec_stb  = 1'b0;
    sync_stb = 1'b0;
    viol     = 1'b0;
    if (trans) begin
      unique case (st)
        ST_HUNT: begin
          if (run_cls == RUN_SYNC) begin
            sync_stb = 1'b1;
            nxt      = ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (run_cls == RUN_SYNC) nxt = ST_BND;
          else if (run_cls == RUN_DBL) begin
            dec_stb = 1'b1;
            nxt     = ST_MID;
          end else begin
            viol = 1'b1;
            nxt  = ST_HUNT;
          end
        end
        ST_BND: begin
          if (run_cls == RUN_HALF) begin
            dec_stb = 1'b1;
            nxt     = ST_MID;
          end else if (run_cls == RUN_SYNC) begin
            sync_stb = 1'b1;
            nxt      = ST_SYNC;
          end else begin
            viol = 1'b1;
            nxt  = ST_HUNT;
          end
        end
        ST_MID: begin
          if (run_cls == RUN_HALF) nxt = ST_BND;
          else if (run_cls == RUN_FULL) dec_stb = 1'b1;
          else if (run_cls == RUN_DBL) begin
            sync_stb = 1'b1;
            nxt      = ST_SYNC;
          end else begin
            viol = 1'b1;
            nxt  = ST_HUNT;
          end
        end
        default: nxt = ST_HUNT;
      endcase
    end else begin
      if ((st == ST_BND && run_len == lim_bnd) ||
          ((st == ST_MID || st == ST_SYNC) && run_len == lim_mid)) begin
        viol = 1'b1;
        nxt  = ST_HUNT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_HUNT;
    else        st <= nxt;
  end
endmodule

// File: rtl/mdec_out_stage.sv
module mdec_out_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_ticks,
  input  logic             dec_stb,
  input  logic             dec_bit,
  input  logic             sync_stb,
  input  logic             sync_cmd,
  input  logic             viol,
  output logic             nrz_out,
  output logic             bit_clk,
  output logic             valid,
  output logic             cmd_sync
);
  logic [1:0]       good_cnt;
  logic [CNT_W-1:0] hc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nrz_out  <= 1'b0;
      bit_clk  <= 1'b0;
      valid    <= 1'b0;
      cmd_sync <= 1'b0;
      good_cnt <= '0;
      hc       <= '0;
    end else begin
      if (viol) begin
        valid    <= 1'b0;
        good_cnt <= '0;
      end
      if (sync_stb) cmd_sync <= sync_cmd;
      if (dec_stb) begin
        nrz_out <= dec_bit;
        bit_clk <= 1'b0;
        hc      <= half_ticks;
        if (good_cnt == 2'd1) valid <= 1'b1;
        if (good_cnt != 2'd2) good_cnt <= good_cnt + 2'd1;
      end else if (hc != '0) begin
        hc <= hc - 1'b1;
        if (hc == CNT_W'(1)) bit_clk <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/manch_sync_decoder.sv
module manch_sync_decoder
  import mdec_pkg::*;
#(
  parameter int OSR_LO      = 16,
  parameter int OSR_HI      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  input  logic bip_zero,
  input  logic bip_one,
  input  logic uni_in,
  output logic nrz_out,
  output logic bit_clk,
  output logic valid,
  output logic cmd_sync
);
  localparam int CNT_W = $clog2((9 * OSR_HI) / 4 + 1) + 1;

  logic             trans_w, lvl_w;
  logic [CNT_W-1:0] run_len_w, q_w, half_w;
  mdec_run_e        cls_w;
  logic             dec_stb_w, dec_bit_w, sync_stb_w, sync_cmd_w, viol_w;

  mdec_line_in #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .bip_zero(bip_zero), .bip_one(bip_one),
    .uni_in(uni_in), .trans(trans_w), .lvl(lvl_w)
  );

  mdec_run_timer #(.OSR_LO(OSR_LO), .OSR_HI(OSR_HI), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .trans(trans_w),
    .run_len(run_len_w), .run_cls(cls_w), .q_ticks(q_w), .half_ticks(half_w)
  );

  mdec_frame_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trans(trans_w), .lvl(lvl_w),
    .run_len(run_len_w), .run_cls(cls_w), .q_ticks(q_w),
    .dec_stb(dec_stb_w), .dec_bit(dec_bit_w), .sync_stb(sync_stb_w),
    .sync_cmd(sync_cmd_w), .viol(viol_w)
  );

  mdec_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .half_ticks(half_w),
    .dec_stb(dec_stb_w), .dec_bit(dec_bit_w), .sync_stb(sync_stb_w),
    .sync_cmd(sync_cmd_w), .viol(viol_w),
    .nrz_out(nrz_out), .bit_clk(bit_clk), .valid(valid), .cmd_sync(cmd_sync)
  );
endmodule

// File: rtl/mdec_checker.sv
module mdec_checker (
  input logic clk,
  input logic rst_n,
  input logic nrz_out,
  input logic bit_clk,
  input logic valid,
  input logic cmd_sync,
  input logic trans_seen,
  input logic viol_seen
);
  logic rst_q = 1'b0;

  always @(posedge clk) begin
    if (rst_q)
      AST_RESET_QUIET: assert (!nrz_out && !bit_clk && !valid && !cmd_sync); // R5
    rst_q <= !rst_n;
  end

  AST_NRZ_WHILE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nrz_out) |-> !bit_clk); // R4

  AST_VALID_RISE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> (!bit_clk && $past(trans_seen))); // R6

  AST_SYNC_TYPE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_sync) |-> ($past(trans_seen) || $past(!rst_n))); // R7

  AST_VALID_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> ($past(viol_seen) || $past(!rst_n))); // R8
endmodule

bind manch_sync_decoder mdec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .nrz_out(nrz_out), .bit_clk(bit_clk),
  .valid(valid), .cmd_sync(cmd_sync), .trans_seen(trans_w), .viol_seen(viol_w)
);

// File: tb/manch_sync_decoder_tb.sv
`timescale 1ns/1ps
module manch_sync_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_sel = 1'b0;
  logic bip_zero = 1'b1, bip_one = 1'b0, uni_in = 1'b0;
  logic nrz_out, bit_clk, valid, cmd_sync;
  logic uni_mode = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic   rx_bit [64];
  logic   rx_val [64];
  longint rx_t   [64];
  int     rx_n = 0;

  always #4 clk = ~clk;

  manch_sync_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .bip_zero(bip_zero),
    .bip_one(bip_one), .uni_in(uni_in), .nrz_out(nrz_out), .bit_clk(bit_clk),
    .valid(valid), .cmd_sync(cmd_sync)
  );

  always @(posedge bit_clk) begin
    if (rst_n && rx_n < 64) begin
      rx_bit[rx_n] = nrz_out;
      rx_val[rx_n] = valid;
      rx_t[rx_n]   = $time;
      rx_n         = rx_n + 1;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic drive(input logic l, input int ticks);
    if (uni_mode) begin uni_in = l; bip_zero = 1'b1; bip_one = 1'b0; end
    else          begin uni_in = 1'b0; bip_one = l; bip_zero = ~l; end
    repeat (ticks) @(negedge clk);
  endtask

  task automatic send_frame(input bit cmd, input logic [15:0] bits, input int nb,
                            input int h, input bit lead);
    if (lead) drive(~cmd, 4*h);
    drive(cmd, 3*h);
    drive(~cmd, 3*h);
    for (int i = 0; i < nb; i++) begin
      drive(bits[i], h);
      drive(~bits[i], h);
    end
  endtask

  task automatic check_rx(input string tag, input logic [15:0] bits, input int nb,
                          input logic [15:0] vexp);
    chk(rx_n == nb, {tag, " bit count"}, rx_n, nb);
    for (int i = 0; i < nb && i < rx_n; i++) begin
      chk(rx_bit[i] == bits[i], {tag, " R3 data bit"}, rx_bit[i], bits[i]);
      chk(rx_val[i] == vexp[i], {tag, " R6 valid at bit"}, rx_val[i], vexp[i]);
    end
  endtask

  // R5: reset forces outputs low even with line activity
  task automatic t_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 6; i++) drive(i[0], 3);
    chk(!nrz_out && !bit_clk && !valid && !cmd_sync, "R5 outputs in reset",
        {nrz_out, bit_clk, valid, cmd_sync}, 0);
    drive(1'b0, 4);
    rst_n = 1'b1;
    drive(1'b0, 40);
  endtask

  // R1 pair input, R2 16x rate, R3, R6, R7 command, R8 timeout
  task automatic t_cmd_pair16();
    uni_mode = 1'b0; rate_sel = 1'b0; rx_n = 0;
    send_frame(1'b1, 16'h00B9, 8, 8, 1'b1);
    repeat (12) @(negedge clk);
    check_rx("R1 pair", 16'h00B9, 8, 16'hFFFE);
    chk(cmd_sync == 1'b1, "R7 command sync", cmd_sync, 1);
    if (rx_n >= 4) chk(rx_t[3] - rx_t[2] == 128, "R2 16x bit period", rx_t[3] - rx_t[2], 128);
    repeat (40) @(negedge clk);
    chk(valid == 1'b0, "R8 timeout drops valid", valid, 0);
  endtask

  // R1 single-ended input, R2 32x rate, R7 data sync
  task automatic t_data_uni32();
    uni_mode = 1'b1; rate_sel = 1'b1; rx_n = 0;
    drive(1'b0, 64);
    send_frame(1'b0, 16'h0056, 7, 16, 1'b1);
    repeat (24) @(negedge clk);
    check_rx("R1 single", 16'h0056, 7, 16'hFFFE);
    chk(cmd_sync == 1'b0, "R7 data sync", cmd_sync, 0);
    if (rx_n >= 3) chk(rx_t[2] - rx_t[1] == 256, "R2 32x bit period", rx_t[2] - rx_t[1], 256);
    repeat (100) @(negedge clk);
    uni_mode = 1'b0; rate_sel = 1'b0;
    drive(1'b0, 64);
  endtask

  // R9: sync end and first bit share one double run; tolerance windows
  task automatic t_double_and_jitter();
    rx_n = 0;
    send_frame(1'b1, 16'h0006, 4, 8, 1'b1);
    repeat (12) @(negedge clk);
    check_rx("R9 double run", 16'h0006, 4, 16'hFFFE);
    repeat (40) @(negedge clk);
    rx_n = 0;
    send_frame(1'b1, 16'h003A, 6, 7, 1'b1);
    repeat (12) @(negedge clk);
    check_rx("R9 short halves", 16'h003A, 6, 16'hFFFE);
    repeat (40) @(negedge clk);
    rx_n = 0;
    send_frame(1'b1, 16'h002D, 6, 9, 1'b1);
    repeat (12) @(negedge clk);
    check_rx("R9 long halves", 16'h002D, 6, 16'hFFFE);
    repeat (48) @(negedge clk);
  endtask

  // R10: word followed directly by a data sync whose first half merges
  task automatic t_back_to_back();
    rx_n = 0;
    send_frame(1'b1, 16'h0009, 4, 8, 1'b1);
    chk(cmd_sync == 1'b1, "R10 first word command", cmd_sync, 1);
    send_frame(1'b0, 16'h000B, 4, 8, 1'b0);
    repeat (12) @(negedge clk);
    check_rx("R10 back to back", 16'h00B9, 8, 16'hFFFE);
    chk(cmd_sync == 1'b0, "R10 sync type switches", cmd_sync, 0);
    repeat (48) @(negedge clk);
  endtask

  // R8: cell without mid transition, then recovery needs sync plus two bits
  task automatic t_violation();
    rx_n = 0;
    send_frame(1'b1, 16'h0005, 4, 8, 1'b1);
    drive(1'b0, 16);
    drive(1'b1, 6);
    chk(rx_n == 4 && rx_val[3] == 1'b1, "R8 valid before violation", rx_val[3], 1);
    chk(valid == 1'b0, "R8 missing mid transition", valid, 0);
    chk(rx_n == 4, "R8 no bit after violation", rx_n, 4);
    drive(1'b1, 32);
    rx_n = 0;
    send_frame(1'b1, 16'h0006, 3, 8, 1'b1);
    repeat (12) @(negedge clk);
    check_rx("R8 resync", 16'h0006, 3, 16'hFFFE);
    repeat (48) @(negedge clk);
  endtask

  // R5 reset mid-stream; R6 no decode without sync
  task automatic t_reset_mid();
    rx_n = 0;
    send_frame(1'b1, 16'h0035, 6, 8, 1'b1);
    repeat (4) @(negedge clk);
    chk(valid == 1'b1, "R6 valid before reset", valid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!nrz_out && !bit_clk && !valid && !cmd_sync, "R5 mid-stream reset",
        {nrz_out, bit_clk, valid, cmd_sync}, 0);
    rst_n = 1'b1;
    rx_n = 0;
    for (int i = 0; i < 8; i++) begin
      drive(i[1], 8);
      drive(~i[1], 8);
    end
    repeat (12) @(negedge clk);
    chk(rx_n == 0, "R6 no bits without sync", rx_n, 0);
    chk(!valid && !bit_clk && !nrz_out, "R6 quiet without sync",
        {valid, bit_clk, nrz_out}, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cmd_pair16();
    t_data_uni32();
    t_double_and_jitter();
    t_back_to_back();
    t_violation();
    t_reset_mid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule